// File: doc/BRIEF.md
# SIMD Lane Divergence Mask Unit

This block sits beside the shared fetch/decode stage of an eight-lane SIMD group. All lanes run one instruction stream. When that stream reaches a data-dependent branch, each lane reports its own condition bit. The unit turns those bits into an active-lane mask. The mask drives the writeback enables of the lanes, so lanes that are not on the current path compute but do not commit results.

A sequencer drives three strobes: open a branch, switch to the alternative path, and close the branch. On open, only the lanes that are both active and true stay enabled. On switch, only the lanes that were active at the open and false stay enabled. On close, the mask that was in force before the open comes back, so every lane resumes the common code together.

Nesting is handled by a stack of saved masks. Pushing onto a full stack sets a sticky error flag. The unit also has two helper outputs for the sequencer and for utilisation checks:
- A skip indication, raised when the current path has no lanes at all, so the sequencer can step over that path.
- A live count of enabled lanes.

Top module: `simd_div_mask`

## Requirements
- R1: After reset the mask is all ones, the lane count equals LANES, and both the skip and error outputs are low.
- R2: A branch strobe makes the mask, from the next cycle, the bitwise AND of the current mask and the condition vector (bit i is lane i). Lanes already disabled stay disabled whatever their condition.
- R3: An else strobe with a branch open makes the mask equal to the mask saved at that branch's open, ANDed with the inverse of the mask that the open produced.
- R4: An endif strobe with a branch open restores the mask saved at that branch's open and closes it. Closing the outermost branch restores all ones.
- R5: The skip output is high exactly while the mask is all zero. A condition that is all true empties the else path, and one that is all false empties the taken path.
- R6: Branches nest up to DEPTH levels (4 by default). Each else and endif acts on the innermost open branch.
- R7: A branch strobe while DEPTH branches are open leaves the mask and the stack unchanged and sets the error output. The error output stays high until reset.
- R8: An else or endif strobe with no branch open has no effect on the mask.
- R9: The count output always equals the number of ones in the mask, down to 1 when a single lane is active (1/8 utilisation).
- R10: When several strobes arrive in one cycle, only one acts: branch over else, and else over endif.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | LANES | Per-lane branch condition, bit i for lane i |
| br_i | input | 1 | Open a branch using cond_i |
| else_i | input | 1 | Switch to the alternative path of the innermost branch |
| endif_i | input | 1 | Close the innermost branch |
| mask_o | output | LANES | Active-lane mask gating writeback |
| active_cnt_o | output | $clog2(LANES+1) | Number of active lanes |
| skip_o | output | 1 | Current path has no active lane |
| err_o | output | 1 | Sticky nesting overflow flag |

## Verification
The bench builds the unit with LANES=8, DEPTH=4 and the adder-tree lane counter. Eight lanes let hand-chosen condition bytes cover the partial, uniform and single-lane cases. A depth of four means five nested opens are enough to reach the overflow path and the sticky flag. Nesting three levels deep brings the else and endif handling of inner branches within reach, as well as the restore of partial parent masks.

// File: rtl/simd_div_pkg.sv
package simd_div_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_BRANCH = 2'd1,
      OP_ELSE   = 2'd2,
      OP_ENDIF  = 2'd3
   } div_op_e;

   // one strobe wins per cycle: branch, then else, then endif
   function automatic div_op_e pick_op(input logic br, input logic el, input logic en);
      if (br)      return OP_BRANCH;
      else if (el) return OP_ELSE;
      else if (en) return OP_ENDIF;
      else         return OP_NONE;
   endfunction

endpackage

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
   parameter int LANES = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [LANES-1:0] par_i,
   input  logic [LANES-1:0] tak_i,
   output logic [LANES-1:0] top_par_o,
   output logic [LANES-1:0] top_tak_o,
   output logic             full_o,
   output logic             empty_o,
   output logic [$clog2(DEPTH+1)-1:0] level_o
);
   localparam int PW = $clog2(DEPTH+1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin
      assert (DEPTH >= 4) else $error("mask stack needs DEPTH >= 4");
      assert (LANES >= 2) else $error("mask stack needs LANES >= 2");
   end

   logic [LANES-1:0] par_q [DEPTH];
   logic [LANES-1:0] tak_q [DEPTH];
   logic [PW-1:0]    ptr_q;
   logic [IW-1:0]    wr_idx;
   logic [IW-1:0]    top_idx;

   assign wr_idx  = IW'(ptr_q);
   assign top_idx = IW'(ptr_q - PW'(1));
   assign full_o  = (ptr_q == PW'(DEPTH));
   assign empty_o = (ptr_q == '0);
   assign level_o = ptr_q;
   assign top_par_o = empty_o ? '1 : par_q[top_idx];
   assign top_tak_o = empty_o ? '1 : tak_q[top_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            par_q[i] <= '1;
            tak_q[i] <= '1;
         end
      end else if (push_i && !full_o) begin
         par_q[wr_idx] <= par_i;
         tak_q[wr_idx] <= tak_i;
         ptr_q <= ptr_q + PW'(1);
      end else if (pop_i && !empty_o) begin
         ptr_q <= ptr_q - PW'(1);
      end
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);

   // R6
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PW'(DEPTH));

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> !pop_i);

endmodule

// File: rtl/simd_lane_count.sv
module simd_lane_count #(
   parameter int LANES = 8,
   parameter bit TREE  = 1'b1
) (
   input  logic [LANES-1:0]          lanes_i,
   output logic [$clog2(LANES+1)-1:0] cnt_o
);
   localparam int CW  = $clog2(LANES+1);
   localparam int PAD = 1 << $clog2(LANES);

   generate
      if (TREE) begin : g_tree
         logic [CW-1:0] node [2*PAD-1];
         for (genvar i = 0; i < PAD; i++) begin : g_leaf
            if (i < LANES) begin : g_real
               assign node[PAD-1+i] = CW'(lanes_i[i]);
            end else begin : g_pad
               assign node[PAD-1+i] = '0;
            end
         end
         for (genvar j = 0; j < PAD-1; j++) begin : g_sum
            assign node[j] = node[2*j+1] + node[2*j+2];
         end
         assign cnt_o = node[0];
      end else begin : g_linear
         always_comb begin
            cnt_o = '0;
            for (int k = 0; k < LANES; k++) cnt_o = cnt_o + CW'(lanes_i[k]);
         end
      end
   endgenerate

endmodule

// File: rtl/simd_div_mask.sv
module simd_div_mask
   import simd_div_pkg::*;
#(
   parameter int LANES    = 8,
   parameter int DEPTH    = 4,
   parameter bit CNT_TREE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            cond_i,
   input  logic                        br_i,
   input  logic                        else_i,
   input  logic                        endif_i,
   output logic [LANES-1:0]            mask_o,
   output logic [$clog2(LANES+1)-1:0]  active_cnt_o,
   output logic                        skip_o,
   output logic                        err_o
);
   localparam int CW = $clog2(LANES+1);
   localparam int PW = $clog2(DEPTH+1);

   initial begin
      assert (LANES >= 2 && LANES <= 64) else $error("LANES out of range");
   end

   div_op_e          op;
   logic [LANES-1:0] mask_q, mask_d;
   logic             err_q;
   logic             push, pop;
   logic [LANES-1:0] top_par, top_tak;
   logic             st_full, st_empty;
   logic [PW-1:0]    level;

   assign op   = pick_op(br_i, else_i, endif_i);
   assign push = (op == OP_BRANCH) && !st_full;
   assign pop  = (op == OP_ENDIF) && !st_empty;

   simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (push),
      .pop_i     (pop),
      .par_i     (mask_q),
      .tak_i     (mask_q & cond_i),
      .top_par_o (top_par),
      .top_tak_o (top_tak),
      .full_o    (st_full),
      .empty_o   (st_empty),
      .level_o   (level)
   );

   always_comb begin
      mask_d = mask_q;
      unique case (op)
         OP_BRANCH: if (!st_full)  mask_d = mask_q & cond_i;
         OP_ELSE:   if (!st_empty) mask_d = top_par & ~top_tak;
         OP_ENDIF:  if (!st_empty) mask_d = top_par;
         default:   mask_d = mask_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         err_q  <= 1'b0;
      end else begin
         mask_q <= mask_d;
         if (op == OP_BRANCH && st_full) err_q <= 1'b1;
      end
   end

   simd_lane_count #(.LANES(LANES), .TREE(CNT_TREE)) u_count (
      .lanes_i (mask_q),
      .cnt_o   (active_cnt_o)
   );

   assign mask_o = mask_q;
   assign skip_o = (mask_q == '0);
   assign err_o  = err_q;

   // R2
   branch_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_i && !st_full) |=> (mask_o & ~$past(mask_o & cond_i)) == '0);

   // R3
   else_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (else_i && !br_i && !st_empty) |=> (mask_o & $past(top_tak)) == '0);

   // R4
   outer_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (endif_i && !else_i && !br_i && level == PW'(1)) |=> (&mask_o));

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R7
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_i && st_full) |=> $stable(mask_o));

   // R8
   idle_else_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((else_i || endif_i) && !br_i && st_empty) |=> $stable(mask_o));

   // R9
   count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_cnt_o == CW'($countones(mask_o)));

endmodule

// File: tb/test_simd_div_mask.sv
module test_simd_div_mask;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cond = '0;
   logic       br = 1'b0, el = 1'b0, en = 1'b0;
   logic [7:0] mask;
   logic [3:0] cnt;
   logic       skip, err;
   int         checks = 0;
   int         errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_div_mask #(.LANES(8), .DEPTH(4), .CNT_TREE(1'b1)) i_simd_div_mask (
      .clk(clk), .rst_n(rst_n), .cond_i(cond), .br_i(br), .else_i(el),
      .endif_i(en), .mask_o(mask), .active_cnt_o(cnt), .skip_o(skip), .err_o(err)
   );

   task automatic check(input string req, input logic [7:0] em, input int ec,
                        input logic es, input logic ee);
      checks++;
      if (mask !== em || int'(cnt) != ec || skip !== es || err !== ee) begin
         errors++;
         $display("FAIL %s: mask=%h cnt=%0d skip=%b err=%b expected mask=%h cnt=%0d skip=%b err=%b",
                  req, mask, cnt, skip, err, em, ec, es, ee);
      end
   endtask

   // drive at negedge, let one edge act, sample 1 time unit after it
   task automatic pulse(input logic b, input logic e, input logic n, input logic [7:0] c);
      cond = c; br = b; el = e; en = n;
      @(posedge clk); #1;
      br = 1'b0; el = 1'b0; en = 1'b0;
   endtask

   task automatic align();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1 check("R1 reset", 8'hFF, 8, 1'b0, 1'b0);
   endtask

   task automatic t_basic();
      pulse(1, 0, 0, 8'h2B); check("R2 branch", 8'h2B, 4, 0, 0); align();
      pulse(0, 1, 0, 8'h00); check("R3 else", 8'hD4, 4, 0, 0); align();
      pulse(0, 0, 1, 8'h00); check("R4 endif", 8'hFF, 8, 0, 0); align();
   endtask

   task automatic t_uniform();
      pulse(1, 0, 0, 8'hFF); check("R5 all-true taken", 8'hFF, 8, 0, 0); align();
      pulse(0, 1, 0, 8'h00); check("R5 all-true else empty", 8'h00, 0, 1, 0); align();
      pulse(0, 0, 1, 8'h00); check("R4 endif after uniform", 8'hFF, 8, 0, 0); align();
      pulse(1, 0, 0, 8'h00); check("R5 all-false taken empty", 8'h00, 0, 1, 0); align();
      pulse(0, 1, 0, 8'h00); check("R5 all-false else full", 8'hFF, 8, 0, 0); align();
      pulse(0, 0, 1, 8'h00); check("R4 endif", 8'hFF, 8, 0, 0); align();
   endtask

   task automatic t_nest();
      pulse(1, 0, 0, 8'hF0); check("R6 level1", 8'hF0, 4, 0, 0); align();
      pulse(1, 0, 0, 8'h3C); check("R2 disabled lanes stay off", 8'h30, 2, 0, 0); align();
      pulse(1, 0, 0, 8'h10); check("R9 single lane", 8'h10, 1, 0, 0); align();
      pulse(0, 1, 0, 8'h00); check("R6 inner else", 8'h20, 1, 0, 0); align();
      pulse(0, 0, 1, 8'h00); check("R6 inner endif", 8'h30, 2, 0, 0); align();
      pulse(0, 1, 0, 8'h00); check("R6 mid else", 8'hC0, 2, 0, 0); align();
      pulse(0, 0, 1, 8'h00); check("R6 mid endif", 8'hF0, 4, 0, 0); align();
      pulse(0, 1, 0, 8'h00); check("R6 outer else", 8'h0F, 4, 0, 0); align();
      pulse(0, 0, 1, 8'h00); check("R4 outer endif", 8'hFF, 8, 0, 0); align();
   endtask

   task automatic t_idle();
      pulse(0, 1, 0, 8'h00); check("R8 else with none open", 8'hFF, 8, 0, 0); align();
      pulse(0, 0, 1, 8'h00); check("R8 endif with none open", 8'hFF, 8, 0, 0); align();
   endtask

   task automatic t_prio();
      pulse(1, 1, 0, 8'h0F); check("R10 branch beats else", 8'h0F, 4, 0, 0); align();
      pulse(0, 1, 1, 8'h00); check("R10 else beats endif", 8'hF0, 4, 0, 0); align();
      pulse(0, 0, 1, 8'h00); check("R10 single close", 8'hFF, 8, 0, 0); align();
   endtask

   task automatic t_ovf();
      for (int i = 0; i < 3; i++) begin
         pulse(1, 0, 0, 8'hFF); align();
      end
      pulse(1, 0, 0, 8'h7F); check("R6 depth4", 8'h7F, 7, 0, 0); align();
      pulse(1, 0, 0, 8'h01); check("R7 overflow ignored", 8'h7F, 7, 0, 1); align();
      pulse(0, 0, 1, 8'h00); check("R7 innermost intact", 8'hFF, 8, 0, 1); align();
      for (int i = 0; i < 3; i++) begin
         pulse(0, 0, 1, 8'h00); align();
      end
      check("R7 error sticky", 8'hFF, 8, 0, 1);
      do_reset();
      #1 check("R1 reset clears error", 8'hFF, 8, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      align();
      t_basic();
      t_uniform();
      t_nest();
      t_idle();
      t_prio();
      t_ovf();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule